// File: doc/BRIEF.md
# I2C master clock generator

This block turns the system clock into the serial clock of a two-wire bus master. The clock has separately programmable low and high phases. A byte-level controller sits next to it and uses two single-cycle strobes. One marks the first cycle of every low phase, where the controller may change the data line. The other marks the middle of every high phase, where the controller samples the data line. The controller can also stretch a low phase with a hold input, for example while it waits for its next byte.

One configuration word holds both phase dividers and a shared power-of-two prescaler. Each phase lasts `(divider << prescaler) + 4` system clock cycles, so equal dividers give a 50% duty cycle. The block reads the configuration only at the start of each low phase. A change made during a period therefore takes effect in the next period, and the low and high halves of one period always come from the same word. A synchronous soft reset and the enable input both return the clock to its idle-high state.

Top module: `scl_clkgen`

## Requirements
- R1: After `rst_ni` is released, and one cycle after any cycle with `en_i` low, `scl_o` is 1 and both strobes are 0.
- R2: The configuration word is packed as bits 18:16 = prescaler exponent `p`, bits 15:8 = high divider, bits 7:0 = low divider. Each low phase without hold lasts exactly `(low_div << p) + 4` cycles.
- R3: Each high phase lasts exactly `(high_div << p) + 4` cycles. Equal dividers give low and high phases of equal length.
- R4: The extremes are exact. A divider of 0 gives a 4-cycle phase at any prescaler. A divider of 255 with `p` = 7 gives a 32644-cycle phase.
- R5: `change_stb_o` is 1 on the first cycle of every low phase and on no other cycle.
- R6: `sample_stb_o` is 1 exactly once in each high phase. It fires on high cycle `floor(Nh/2)`, counting from 0, where `Nh` is the high-phase length.
- R7: Each cycle that `hold_i` is seen high during a low phase freezes the low counter. The low phase grows by that many cycles and `scl_o` stays 0.
- R8: `hold_i` has no effect during a high phase.
- R9: The configuration is captured on the first cycle of each low phase. A change to `cfg_i` later in a period first affects the following period.
- R10: A cycle with `soft_rst_i` high makes `scl_o` 1 and both strobes 0 on the next cycle. With `en_i` still high, a fresh full-length low phase then begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the clock idle high |
| soft_rst_i | input | 1 | Synchronous reset of the phase logic |
| cfg_i | input | 19 | {prescaler[2:0], high_div[7:0], low_div[7:0]} |
| hold_i | input | 1 | Freezes the low phase while high |
| scl_o | output | 1 | Generated serial clock |
| change_stb_o | output | 1 | First cycle of a low phase |
| sample_stb_o | output | 1 | Middle cycle of a high phase |

## Verification
The assertions check several properties on every cycle. A falling clock always comes with the change strobe, and that strobe never lasts two cycles. The sample strobe fires only while the clock is high. A held low phase keeps its counter and stays low. The phase counters stay below their latched lengths, the latched lengths do not move inside a low phase, and the block goes idle after a soft reset or a dropped enable. Only the bench scenarios can show the exact phase lengths and the position of the sample strobe. They also show that a held low stretches by exactly the number of held cycles and that hold in a high phase changes nothing. The same goes for the one-period delay of a configuration change and the full length of the first phase after a soft reset.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int unsigned DIV_W_DEF = 8;
  localparam int unsigned PRE_W_DEF = 3;
  localparam int unsigned PH_OFFSET = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned OFFSET = 4
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] scaled;

  assign scaled = CNT_W'(div_i) << pre_i;
  assign len_o  = scaled + CNT_W'(OFFSET);
endmodule

// File: rtl/scl_len_regs.sv
module scl_len_regs #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned OFFSET = 4,
  localparam int unsigned CFG_W = 2*DIV_W + PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] len_lo_o,
  output logic [CNT_W-1:0] len_hi_o
);
  localparam int unsigned PRE_LSB = 2*DIV_W;

  logic [CNT_W-1:0] len_d [2];
  logic [CNT_W-1:0] len_q [2];

  // index 0: low phase (cfg[DIV_W-1:0]); index 1: high phase
  for (genvar g = 0; g < 2; g++) begin : g_phase
    scl_phase_len #(
      .DIV_W (DIV_W),
      .PRE_W (PRE_W),
      .CNT_W (CNT_W),
      .OFFSET(OFFSET)
    ) u_len (
      .div_i(cfg_i[g*DIV_W +: DIV_W]),
      .pre_i(cfg_i[PRE_LSB +: PRE_W]),
      .len_o(len_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     len_q[g] <= CNT_W'(OFFSET);
      else if (load_i) len_q[g] <= len_d[g];
    end
  end

  assign len_lo_o = len_q[0];
  assign len_hi_o = len_q[1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             srst_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] len_lo_i,
  input  logic [CNT_W-1:0] len_hi_i,
  output logic             load_o,
  output logic             scl_o,
  output logic             chg_stb_o,
  output logic             smp_stb_o
);
  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             chg_q, chg_d;
  logic [CNT_W-1:0] half_hi;

  assign half_hi = len_hi_i >> 1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    chg_d  = 1'b0;
    load_o = 1'b0;
    if (srst_i || !en_i) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          st_d   = PH_LOW;
          cnt_d  = '0;
          chg_d  = 1'b1;
          load_o = 1'b1;
        end
        PH_LOW: begin
          if (!hold_i) begin
            if (cnt_q == len_lo_i - 1'b1) begin
              st_d  = PH_HIGH;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (cnt_q == len_hi_i - 1'b1) begin
            st_d   = PH_LOW;
            cnt_d  = '0;
            chg_d  = 1'b1;
            load_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      chg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      chg_q <= chg_d;
    end
  end

  assign scl_o     = (st_q != PH_LOW);
  assign chg_stb_o = chg_q;
  assign smp_stb_o = (st_q == PH_HIGH) && (cnt_q == half_hi);

  a_r1_idle_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !chg_stb_o && !smp_stb_o));

  a_r2_low_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_LOW) |-> (cnt_q < len_lo_i));

  a_r3_high_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_HIGH) |-> (cnt_q < len_hi_i));

  a_r5_fall_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> chg_stb_o);

  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_stb_o |=> !chg_stb_o);

  a_r6_sample_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_o |-> scl_o);

  a_r7_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_LOW) && hold_i && en_i && !srst_i) |=>
      ((st_q == PH_LOW) && $stable(cnt_q) && !scl_o));

  a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (scl_o && !chg_stb_o && !smp_stb_o && (cnt_q == '0)));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned PRE_W  = PRE_W_DEF,
  localparam int unsigned CFG_W = 2*DIV_W + PRE_W,
  localparam int unsigned CNT_W = DIV_W + (1 << PRE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             soft_rst_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             hold_i,
  output logic             scl_o,
  output logic             change_stb_o,
  output logic             sample_stb_o
);
  logic             cfg_load;
  logic [CNT_W-1:0] len_lo_q;
  logic [CNT_W-1:0] len_hi_q;

  scl_len_regs #(
    .DIV_W (DIV_W),
    .PRE_W (PRE_W),
    .CNT_W (CNT_W),
    .OFFSET(PH_OFFSET)
  ) u_len_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cfg_load),
    .cfg_i   (cfg_i),
    .len_lo_o(len_lo_q),
    .len_hi_o(len_hi_q)
  );

  scl_phase_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .srst_i   (soft_rst_i),
    .hold_i   (hold_i),
    .len_lo_i (len_lo_q),
    .len_hi_i (len_hi_q),
    .load_o   (cfg_load),
    .scl_o    (scl_o),
    .chg_stb_o(change_stb_o),
    .smp_stb_o(sample_stb_o)
  );

  // lengths must not move once a low phase has begun
  a_r9_len_fixed_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_o && !$past(scl_o)) |-> ($stable(len_lo_q) && $stable(len_hi_q)));
endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  typedef struct {
    int lo;
    int hi;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [18:0] cfg_i = '0;
  logic        hold_i = 1'b0;
  logic        scl_o;
  logic        change_stb_o;
  logic        sample_stb_o;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   mon_en = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  scl_clkgen u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .soft_rst_i  (soft_rst_i),
    .cfg_i       (cfg_i),
    .hold_i      (hold_i),
    .scl_o       (scl_o),
    .change_stb_o(change_stb_o),
    .sample_stb_o(sample_stb_o)
  );

  function automatic logic [18:0] mk(int pre, int hi, int lo);
    return {pre[2:0], hi[7:0], lo[7:0]};
  endfunction

  function automatic int plen(int div, int pre);
    return (div << pre) + 4;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(int lo, int hi);
    exp_t e;
    e.lo = lo;
    e.hi = hi;
    q.push_back(e);
  endtask

  task automatic go(logic [18:0] c);
    @(negedge clk_i);
    cfg_i  = c;
    en_i   = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic wait_chg(int n);
    repeat (n) begin
      @(negedge clk_i);
      while (!change_stb_o) @(negedge clk_i);
    end
  endtask

  task automatic drain();
    wait (q.size() == 0);
    mon_en = 1'b0;
    en_i   = 1'b0;
    @(negedge clk_i);
    chk("R1", "scl idle after disable", int'(scl_o), 1);
    chk("R1", "strobes idle after disable", int'(change_stb_o | sample_stb_o), 0);
  endtask

  // monitor: measures phases and compares against the expected queue
  bit scl_prev = 1'b1;
  bit armed_lo = 1'b0;
  bit armed_hi = 1'b0;
  int run = 0;
  int smp_n = 0;
  int smp_at = 0;

  always @(negedge clk_i) begin
    if (!mon_en) begin
      armed_lo = 1'b0;
      armed_hi = 1'b0;
      scl_prev = scl_o;
      run = 0;
      smp_n = 0;
      smp_at = 0;
    end else begin
      if (scl_o != scl_prev) begin
        if (!scl_o) begin
          if (armed_hi) begin
            exp_t e;
            e = q.pop_front();
            chk("R3", "high length", run, e.hi);
            chk("R6", "sample strobe count", smp_n, 1);
            chk("R6", "sample strobe position", smp_at, e.hi / 2 + 1);
            armed_hi = 1'b0;
          end
          chk("R5", "change strobe at low start", int'(change_stb_o), 1);
          armed_lo = 1'b1;
        end else if (armed_lo) begin
          if (q.size() == 0) chk("R2", "unexpected low phase", run, -1);
          else chk("R2", "low length", run, q[0].lo);
          armed_hi = 1'b1;
        end
        run = 1;
        smp_n = 0;
      end else begin
        run++;
        if (change_stb_o) chk("R5", "change strobe mid phase", 1, 0);
      end
      if (sample_stb_o) begin
        smp_n++;
        smp_at = run;
      end
      scl_prev = scl_o;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "scl in reset", int'(scl_o), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1", "scl after reset", int'(scl_o), 1);
    chk("R1", "strobes after reset", int'(change_stb_o | sample_stb_o), 0);

    // R2 R3: equal dividers, 50% duty
    for (int i = 0; i < 3; i++) push_exp(plen(3, 1), plen(3, 1));
    go(mk(1, 3, 3));
    drain();

    // R2 R3: unequal dividers with prescaler
    for (int i = 0; i < 2; i++) push_exp(plen(5, 2), plen(1, 2));
    go(mk(2, 1, 5));
    drain();

    // R4: zero dividers give 4-cycle phases
    for (int i = 0; i < 3; i++) push_exp(4, 4);
    go(mk(5, 0, 0));
    drain();

    // R4: largest low phase
    push_exp(plen(255, 7), plen(0, 7));
    go(mk(7, 0, 255));
    drain();

    // R9: config changed inside period 2 applies from period 3
    push_exp(plen(2, 0), plen(2, 0));
    push_exp(plen(2, 0), plen(2, 0));
    push_exp(plen(9, 0), plen(4, 0));
    push_exp(plen(9, 0), plen(4, 0));
    go(mk(0, 2, 2));
    wait_chg(2);
    @(negedge clk_i);
    cfg_i = mk(0, 4, 9);
    drain();

    // R7: hold for 5 cycles at start of period 2 low
    push_exp(plen(3, 0), plen(3, 0));
    push_exp(plen(3, 0) + 5, plen(3, 0));
    push_exp(plen(3, 0), plen(3, 0));
    go(mk(0, 3, 3));
    wait_chg(2);
    hold_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R7", "scl held low", int'(scl_o), 0);
    hold_i = 1'b0;
    drain();

    // R8: hold during high is ignored
    push_exp(plen(3, 0), plen(6, 0));
    push_exp(plen(3, 0), plen(6, 0));
    go(mk(0, 6, 3));
    wait_chg(1);
    while (scl_o != 1'b1) @(negedge clk_i);
    hold_i = 1'b1;
    repeat (3) @(negedge clk_i);
    hold_i = 1'b0;
    drain();

    // R10: soft reset mid low phase
    @(negedge clk_i);
    cfg_i = mk(0, 6, 6);
    en_i  = 1'b1;
    wait_chg(1);
    repeat (3) @(negedge clk_i);
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    chk("R10", "scl after soft reset", int'(scl_o), 1);
    chk("R10", "strobes after soft reset", int'(change_stb_o | sample_stb_o), 0);
    soft_rst_i = 1'b0;
    push_exp(plen(6, 0), plen(6, 0));
    mon_en = 1'b1;
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule